// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block stands between one requester and a single-port word memory and turns each accepted request into an indivisible read followed, where needed, by one write. It offers ordinary loads and stores, fetch-and-add, compare-and-swap, and a load-linked / store-conditional pair. A request carries an opcode, a word address, an operand and an expected value. The unit answers with the word that was in memory before the operation and a one-bit success flag.

Only one request is in flight at a time. From the cycle a request is taken until its response has been taken, the request channel is closed, so no other access can land between the read and the write of an atomic operation. A single reservation (a valid bit and an address) backs the load-linked / store-conditional pair. A snoop input reports stores made by other agents, and a matching snoop drops the reservation.

Both channels follow valid/ready rules. A request moves on a clock edge where `req_valid` and `req_ready` are both high. The requester keeps its fields steady while `req_valid` is high and `req_ready` is low. A response moves on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low the unit holds the response unchanged and keeps taking no request. The memory port has a read latency of one cycle: `mem_rdata` holds the addressed word in the cycle after a read strobe.

Top module: `atomic_unit`

## Requirements
- R1: Fetch-and-add (opcode 2) writes old + operand, wrapping modulo 2^DW. It returns the old word with success 1.
- R2: Compare-and-swap (opcode 3) returns the old word. When the old word equals the expected value it writes the operand and reports success 1. Otherwise it reports success 0 and memory is left unchanged.
- R3: Load-linked (opcode 4) returns the word with success 1 and places the reservation on its address.
- R4: Store-conditional (opcode 5) writes the operand and reports success 1 only when the reservation is valid and holds the same address. Otherwise it reports success 0 and writes nothing.
- R5: Every store-conditional clears the reservation, whether it succeeds or fails.
- R6: A snoop (`snoop_valid` high for one cycle) whose address equals the reserved address clears the reservation. A snoop to any other address leaves it in place.
- R7: A local write to the reserved address clears the reservation. This covers a store, a fetch-and-add and a successful compare-and-swap. A local write to another address leaves it in place.
- R8: Once a request is accepted, `req_ready` stays low until its response is taken. Each request makes exactly one memory read, and then at most one write in the following cycle.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_old` and `rsp_ok` hold steady.
- R10: Four fetch-and-add requests of +1 applied to a word that starts at 0 leave it at exactly 4, and they return 0, 1, 2 and 3.
- R11: A load (opcode 0, or any unused code 6 or 7) returns the word with success 1 and writes nothing. A store (opcode 1) writes the operand and returns the old word with success 1.
- R12: After reset `req_ready` is 1, `rsp_valid` is 0, the memory port is idle and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Word address |
| req_operand | input | DW | Addend, store data or swap value |
| req_expect | input | DW | Compare value for compare-and-swap |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_old | output | DW | Memory word before the operation |
| rsp_ok | output | 1 | Success flag |
| snoop_valid | input | 1 | Another agent stored to snoop_addr |
| snoop_addr | input | AW | Address of the snooped store |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after a read |

## Verification
The bench builds the unit with AW = 4 and DW = 8, a 16-word memory of bytes. With that size the wrap of a fetch-and-add past 255 can be reached in one request. The bench checks the reservation against neighbouring addresses, where an error in the address match would show. The narrow data path also makes equal and unequal compare values easy to choose on purpose.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_FADD  = 3'd2,
    OP_CAS   = 3'd3,
    OP_LL    = 3'd4,
    OP_SC    = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_MOD  = 2'd2,
    ST_RESP = 2'd3
  } state_e;
endpackage

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] expect_word,
  input  logic          link_hit,
  output logic          wr,
  output logic [DW-1:0] wdata,
  output logic          ok
);
  logic same;
  assign same = (old_word == expect_word);

  always_comb begin
    wr    = 1'b0;
    wdata = operand;
    ok    = 1'b1;
    case (op)
      OP_STORE: wr = 1'b1;
      OP_FADD: begin
        wr    = 1'b1;
        wdata = old_word + operand;
      end
      OP_CAS: begin
        wr = same;
        ok = same;
      end
      OP_SC: begin
        wr = link_hit;
        ok = link_hit;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/atomic_resv.sv
module atomic_resv #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic          sc_done,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  input  logic [AW-1:0] chk_addr,
  output logic          hit
);
  logic          held;
  logic [AW-1:0] held_addr;
  logic          snoop_kill;
  logic          write_kill;

  assign snoop_kill = snoop_valid && (snoop_addr == held_addr);
  assign write_kill = wr_en && (wr_addr == held_addr);
  assign hit = held && (held_addr == chk_addr) && !snoop_kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_addr <= '0;
    end else if (set_en) begin
      held      <= 1'b1;
      held_addr <= set_addr;
    end else if (sc_done || snoop_kill || write_kill) begin
      held <= 1'b0;
    end
  end

  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done && !set_en) |=> !held); // R5
  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (held && snoop_valid && snoop_addr == held_addr && !set_en) |=> !held); // R6
  AST_LL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (held && held_addr == $past(set_addr))); // R3
endmodule

// File: rtl/atomic_unit.sv
module atomic_unit
  import atomic_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_operand,
  input  logic [DW-1:0] req_expect,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_old,
  output logic          rsp_ok,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  state_e        state;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] old_q;
  logic          ok_q;
  logic          alu_wr;
  logic [DW-1:0] alu_wdata;
  logic          alu_ok;
  logic          link_hit;
  logic          in_mod;

  assign in_mod    = (state == ST_MOD);
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_old   = old_q;
  assign rsp_ok    = ok_q;
  assign mem_we    = in_mod && alu_wr;
  assign mem_en    = (state == ST_READ) || mem_we;
  assign mem_addr  = addr_q;
  assign mem_wdata = alu_wdata;

  atomic_alu #(.DW(DW)) u_alu (
    .op          (op_q),
    .old_word    (mem_rdata),
    .operand     (opnd_q),
    .expect_word (exp_q),
    .link_hit    (link_hit),
    .wr          (alu_wr),
    .wdata       (alu_wdata),
    .ok          (alu_ok)
  );

  atomic_resv #(.AW(AW)) u_resv (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (in_mod && op_q == OP_LL),
    .set_addr    (addr_q),
    .sc_done     (in_mod && op_q == OP_SC),
    .wr_en       (mem_we),
    .wr_addr     (addr_q),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .chk_addr    (addr_q),
    .hit         (link_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      addr_q <= '0;
      opnd_q <= '0;
      exp_q  <= '0;
      old_q  <= '0;
      ok_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          opnd_q <= req_operand;
          exp_q  <= req_expect;
          state  <= ST_READ;
        end
        ST_READ: state <= ST_MOD;
        ST_MOD: begin
          old_q <= mem_rdata;
          ok_q  <= alu_ok;
          state <= ST_RESP;
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  AST_CLOSED_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> $past(mem_en && !mem_we)); // R8
  AST_QUIET_WHILE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_en); // R8
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_old) && $stable(rsp_ok))); // R9
  AST_FADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && op_q == OP_FADD) |-> (mem_wdata == mem_rdata + opnd_q)); // R1
  AST_CAS_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mod && op_q == OP_CAS && mem_rdata != exp_q) |-> !mem_en); // R2
endmodule

// File: tb/atomic_unit_test.sv
`timescale 1ns/1ps
module atomic_unit_test;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [2:0] LD = 3'd0, ST = 3'd1, FA = 3'd2, CS = 3'd3, LL = 3'd4, SC = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_operand = '0;
  logic [DW-1:0] req_expect = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [DW-1:0] rsp_old;
  logic rsp_ok;
  logic snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  int tests = 0;
  int fails = 0;
  int rd_total = 0;
  int wr_total = 0;
  logic [DW-1:0] mem [16];

  always #2 clk = ~clk;

  atomic_unit #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_operand(req_operand), .req_expect(req_expect),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_old(rsp_old), .rsp_ok(rsp_ok),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_total <= wr_total + 1;
      end else begin
        rd_total <= rd_total + 1;
      end
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic check(input string req, input bit good, input string what,
                       input int act, input int exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] opnd, input logic [DW-1:0] ex,
                        output logic [DW-1:0] old, output logic ok);
    int rd0, wr0, open;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd0 = rd_total; wr0 = wr_total; open = 0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_operand = opnd; req_expect = ex;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) open++;
      @(negedge clk);
    end
    if (req_ready) open++;
    old = rsp_old; ok = rsp_ok;
    @(negedge clk);
    check("R8", open == 0, "req_ready high while busy", open, 0);
    check("R8", rd_total - rd0 == 1, "reads per request", rd_total - rd0, 1);
    check("R8", wr_total - wr0 <= 1, "writes per request", wr_total - wr0, 1);
  endtask

  task automatic snoop(input logic [AW-1:0] a);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] o; logic k;
    check("R12", req_ready === 1'b1, "req_ready after reset", req_ready, 1);
    check("R12", rsp_valid === 1'b0, "rsp_valid after reset", rsp_valid, 0);
    check("R12", mem_en === 1'b0, "mem_en after reset", mem_en, 0);
    run_op(SC, 4'd0, 8'h55, 8'h0, o, k);
    check("R12", k == 1'b0, "sc with no reservation", k, 0);
    run_op(LD, 4'd0, 8'h0, 8'h0, o, k);
    check("R4", o == 8'h00, "failed sc left memory", o, 0);
  endtask

  task automatic t_load_store;
    logic [DW-1:0] o; logic k;
    run_op(ST, 4'd3, 8'hA7, 8'h0, o, k);
    check("R11", o == 8'h00 && k, "store old/ok", o, 0);
    run_op(LD, 4'd3, 8'h11, 8'h0, o, k);
    check("R11", o == 8'hA7 && k, "load value", o, 8'hA7);
    run_op(3'd7, 4'd3, 8'h22, 8'h0, o, k);
    check("R11", o == 8'hA7 && k, "unused code acts as load", o, 8'hA7);
    check("R11", mem[3] == 8'hA7, "unused code wrote nothing", mem[3], 8'hA7);
  endtask

  task automatic t_fadd;
    logic [DW-1:0] o; logic k;
    run_op(ST, 4'd5, 8'hFE, 8'h0, o, k);
    run_op(FA, 4'd5, 8'h03, 8'h0, o, k);
    check("R1", o == 8'hFE && k, "fadd old", o, 8'hFE);
    run_op(LD, 4'd5, 8'h0, 8'h0, o, k);
    check("R1", o == 8'h01, "fadd wraps", o, 1);
  endtask

  task automatic t_four_incr;
    logic [DW-1:0] o; logic k;
    run_op(ST, 4'd6, 8'h00, 8'h0, o, k);
    for (int i = 0; i < 4; i++) begin
      run_op(FA, 4'd6, 8'h01, 8'h0, o, k);
      check("R10", o == DW'(i) && k, "increment old", o, i);
    end
    run_op(LD, 4'd6, 8'h0, 8'h0, o, k);
    check("R10", o == 8'd4, "final count", o, 4);
  endtask

  task automatic t_cas;
    logic [DW-1:0] o; logic k;
    run_op(ST, 4'd7, 8'h10, 8'h0, o, k);
    run_op(CS, 4'd7, 8'h20, 8'h11, o, k);
    check("R2", o == 8'h10 && !k, "cas mismatch", k, 0);
    run_op(LD, 4'd7, 8'h0, 8'h0, o, k);
    check("R2", o == 8'h10, "cas mismatch kept memory", o, 8'h10);
    run_op(CS, 4'd7, 8'h20, 8'h10, o, k);
    check("R2", o == 8'h10 && k, "cas match", k, 1);
    run_op(LD, 4'd7, 8'h0, 8'h0, o, k);
    check("R2", o == 8'h20, "cas wrote new", o, 8'h20);
  endtask

  task automatic t_llsc;
    logic [DW-1:0] o; logic k;
    run_op(ST, 4'd8, 8'h33, 8'h0, o, k);
    run_op(LL, 4'd8, 8'h0, 8'h0, o, k);
    check("R3", o == 8'h33 && k, "ll value", o, 8'h33);
    run_op(SC, 4'd8, 8'h44, 8'h0, o, k);
    check("R4", k, "sc after ll", k, 1);
    check("R4", mem[8] == 8'h44, "sc wrote", mem[8], 8'h44);
    run_op(SC, 4'd8, 8'h55, 8'h0, o, k);
    check("R5", !k && mem[8] == 8'h44, "second sc fails", k, 0);
    run_op(LL, 4'd8, 8'h0, 8'h0, o, k);
    run_op(SC, 4'd9, 8'h66, 8'h0, o, k);
    check("R4", !k && mem[9] == 8'h00, "sc other address", k, 0);
    run_op(SC, 4'd8, 8'h77, 8'h0, o, k);
    check("R5", !k && mem[8] == 8'h44, "failed sc cleared link", k, 0);
  endtask

  task automatic t_snoop;
    logic [DW-1:0] o; logic k;
    run_op(LL, 4'd10, 8'h0, 8'h0, o, k);
    snoop(4'd11);
    run_op(SC, 4'd10, 8'h12, 8'h0, o, k);
    check("R6", k, "unrelated snoop kept link", k, 1);
    run_op(LL, 4'd10, 8'h0, 8'h0, o, k);
    snoop(4'd10);
    run_op(SC, 4'd10, 8'h34, 8'h0, o, k);
    check("R6", !k && mem[10] == 8'h12, "matching snoop broke link", k, 0);
  endtask

  task automatic t_local_write;
    logic [DW-1:0] o; logic k;
    run_op(LL, 4'd12, 8'h0, 8'h0, o, k);
    run_op(FA, 4'd13, 8'h01, 8'h0, o, k);
    run_op(SC, 4'd12, 8'h21, 8'h0, o, k);
    check("R7", k, "write elsewhere kept link", k, 1);
    run_op(LL, 4'd12, 8'h0, 8'h0, o, k);
    run_op(ST, 4'd12, 8'h09, 8'h0, o, k);
    run_op(SC, 4'd12, 8'h22, 8'h0, o, k);
    check("R7", !k && mem[12] == 8'h09, "store broke link", k, 0);
    run_op(LL, 4'd12, 8'h0, 8'h0, o, k);
    run_op(FA, 4'd12, 8'h01, 8'h0, o, k);
    run_op(SC, 4'd12, 8'h23, 8'h0, o, k);
    check("R7", !k && mem[12] == 8'h0A, "fadd broke link", k, 0);
  endtask

  task automatic t_backpressure;
    logic [DW-1:0] o0; logic k0; int moved;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = LD; req_addr = 4'd3;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    o0 = rsp_old; k0 = rsp_ok; moved = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_old != o0 || rsp_ok != k0 || req_ready) moved++;
    end
    check("R9", moved == 0, "response held under back-pressure", moved, 0);
    check("R9", o0 == 8'hA7, "held response value", o0, 8'hA7);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8", req_ready && !rsp_valid, "reopens after response taken", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_store();
    t_fadd();
    t_four_incr();
    t_cas();
    t_llsc();
    t_snoop();
    t_local_write();
    t_backpressure();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule